// File: doc/BRIEF.md
# Packed Narrow-Operand Register File

This block is a register file built from 32-bit physical words in which several narrow architectural registers can live side by side in one word. Every architectural register is reached through a mapping table that records which physical word holds it, the bit position where its field starts, how many bits wide the field is, and whether the field is read back as a signed or an unsigned integer. A field whose width was fixed ahead of time (a counter known to stay within 0..50 needs only 6 bits, for example) therefore costs 6 bits of storage rather than a whole word.

Two read ports look up the table, pull the field out of its word, move it down to bit 0 and extend it to 32 bits. One write port looks up the table and merges the new field into its slice with a read-modify-write of the word, so the other fields sharing that word keep their values. The table is loaded through a configuration port before the register file is used; a configuration whose field would run past bit 31, or whose width is zero, is refused and reported on `cfg_err`.

Top module: `pnrf_top`

## Requirements
- R1: After reset every architectural register is unmapped and every physical word is zero; a read of an unmapped register returns 0 and `cfg_err` is 0.
- R2: A configuration write with width `cfg_width` in 1..32 and `cfg_off + cfg_width <= 32` updates the mapping of `cfg_reg`, and `cfg_err` is 0 in the following cycle.
- R3: A configuration write with `cfg_width == 0`, `cfg_width > 32` or `cfg_off + cfg_width > 32` leaves the mapping unchanged and raises `cfg_err` for exactly the following cycle.
- R4: A read of a register whose signed flag is 0 returns bits `[off+width-1:off]` of its word at bits `[width-1:0]`, with all higher bits 0.
- R5: A read of a register whose signed flag is 1 returns the field at bits `[width-1:0]` with bit `width-1` copied into every higher bit.
- R6: A write to a mapped register changes only the bits `[off+width-1:off]` of its physical word; every other field in that word keeps its value.
- R7: Bits of `wr_data` at and above the field width are discarded by a write.
- R8: The two read ports are independent; each returns its own register's value in the same cycle.
- R9: Reads are combinational from the stored state: a read of a register in the cycle it is written returns the old value, and the new value from the next cycle on.
- R10: A write to an unmapped register changes no physical word.
- R11: A 32-bit field at offset 0 stores and returns all 32 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg | input | 4 | Architectural register being configured |
| cfg_phys | input | 3 | Physical word that will hold the field |
| cfg_off | input | 5 | Lowest bit of the field within the word |
| cfg_width | input | 6 | Field width in bits, legal 1..32 |
| cfg_signed | input | 1 | 1 = sign-extend on read, 0 = zero-extend |
| cfg_err | output | 1 | High for one cycle after a refused configuration write |
| rd_addr0 | input | 4 | Read port 0 architectural register |
| rd_data0 | output | 32 | Read port 0 extended field |
| rd_addr1 | input | 4 | Read port 1 architectural register |
| rd_data1 | output | 32 | Read port 1 extended field |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 4 | Architectural register written |
| wr_data | input | 32 | Write value; only the low field-width bits are kept |

## Verification
The assertions assume the configuration port is only used while the read and write ports are quiet, so that a mapping never changes underneath an access in flight, and that mapped fields sharing a word do not overlap. The stimulus loads every mapping in a dedicated phase before any write, packs the fields it places in one word into disjoint slices, and issues refused configurations only against registers whose values it then reads back to show nothing moved.

// File: rtl/pnrf_pkg.sv
package pnrf_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = $clog2(WORD_W);
  localparam int WID_W  = $clog2(WORD_W) + 1;

  typedef struct packed {
    logic             valid;
    logic             sgn;
    logic [OFF_W-1:0] off;
    logic [WID_W-1:0] width;
  } map_t;

  function automatic logic [WORD_W-1:0] field_mask(input logic [WID_W-1:0] width);
    if (width >= WID_W'(WORD_W)) return '1;
    return (WORD_W'(1) << width) - WORD_W'(1);
  endfunction

  function automatic logic cfg_legal(input logic [OFF_W-1:0] off,
                                     input logic [WID_W-1:0] width);
    logic [WID_W:0] top;
    top = {1'b0, width} + (WID_W+1)'(off);
    return (width != '0) && (width <= WID_W'(WORD_W)) && (top <= (WID_W+1)'(WORD_W));
  endfunction

  function automatic logic [WORD_W-1:0] field_extract(input logic [WORD_W-1:0] word,
                                                      input map_t m);
    logic [WORD_W-1:0] msk;
    logic [WORD_W-1:0] val;
    msk = field_mask(m.width);
    val = (word >> m.off) & msk;
    if (!m.valid) return '0;
    if (m.sgn && (m.width < WID_W'(WORD_W)) && (m.width != '0) &&
        val[m.width - WID_W'(1)]) begin
      val = val | ~msk;
    end
    return val;
  endfunction

  function automatic logic [WORD_W-1:0] field_merge(input logic [WORD_W-1:0] word,
                                                    input map_t m,
                                                    input logic [WORD_W-1:0] data);
    logic [WORD_W-1:0] slot;
    slot = field_mask(m.width) << m.off;
    return (word & ~slot) | (((data & field_mask(m.width)) << m.off) & slot);
  endfunction
endpackage

// File: rtl/pnrf_map_table.sv
module pnrf_map_table
  import pnrf_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 8,
  parameter int NUM_LOOK = 3,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_reg,
  input  logic [PW-1:0]          cfg_phys,
  input  logic [OFF_W-1:0]       cfg_off,
  input  logic [WID_W-1:0]       cfg_width,
  input  logic                   cfg_signed,
  output logic                   cfg_err,
  output logic                   map_wr_fire,
  input  logic [NUM_LOOK-1:0][AW-1:0] look_addr,
  output map_t [NUM_LOOK-1:0]    look_map,
  output logic [NUM_LOOK-1:0][PW-1:0] look_phys
);
  map_t           maps  [NUM_ARCH];
  logic [PW-1:0]  phys  [NUM_ARCH];
  logic           legal;

  assign legal       = cfg_legal(cfg_off, cfg_width);
  assign map_wr_fire = cfg_we && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      for (int i = 0; i < NUM_ARCH; i++) begin
        maps[i] <= '0;
        phys[i] <= '0;
      end
    end else begin
      cfg_err <= cfg_we && !legal;
      if (map_wr_fire) begin
        maps[cfg_reg] <= '{valid: 1'b1, sgn: cfg_signed, off: cfg_off, width: cfg_width};
        phys[cfg_reg] <= cfg_phys;
      end
    end
  end

  for (genvar g = 0; g < NUM_LOOK; g++) begin : g_look
    assign look_map[g]  = maps[look_addr[g]];
    assign look_phys[g] = phys[look_addr[g]];
  end
endmodule

// File: rtl/pnrf_storage.sv
module pnrf_storage
  import pnrf_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_RD   = 3,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [PW-1:0]                waddr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [NUM_RD-1:0][PW-1:0]    raddr,
  output logic [NUM_RD-1:0][WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] words [NUM_PHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rdata[g] = words[raddr[g]];
  end
endmodule

// File: rtl/pnrf_extract.sv
module pnrf_extract
  import pnrf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  map_t              m,
  output logic [WORD_W-1:0] value
);
  assign value = field_extract(word, m);
endmodule

// File: rtl/pnrf_top.sv
module pnrf_top
  import pnrf_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 8,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int NUM_RP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_reg,
  input  logic [PW-1:0]     cfg_phys,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              cfg_signed,
  output logic              cfg_err,
  input  logic [AW-1:0]     rd_addr0,
  output logic [WORD_W-1:0] rd_data0,
  input  logic [AW-1:0]     rd_addr1,
  output logic [WORD_W-1:0] rd_data1,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_reg,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int NLOOK = NUM_RP + 1;
  localparam int WSLOT = NUM_RP;

  logic [NLOOK-1:0][AW-1:0]     look_addr;
  map_t [NLOOK-1:0]             look_map;
  logic [NLOOK-1:0][PW-1:0]     look_phys;
  logic [NLOOK-1:0][WORD_W-1:0] words_rd;
  logic [NUM_RP-1:0][WORD_W-1:0] rd_val;
  logic                         map_wr_fire;
  logic                         st_we;
  logic [WORD_W-1:0]            st_wdata;
  map_t                         rd0_map;
  map_t                         wr_map;

  assign look_addr[0]     = rd_addr0;
  assign look_addr[1]     = rd_addr1;
  assign look_addr[WSLOT] = wr_reg;

  pnrf_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_LOOK(NLOOK)) u_table (
    .clk, .rst_n, .cfg_we, .cfg_reg, .cfg_phys, .cfg_off, .cfg_width, .cfg_signed,
    .cfg_err, .map_wr_fire, .look_addr, .look_map, .look_phys
  );

  assign wr_map   = look_map[WSLOT];
  assign rd0_map  = look_map[0];
  assign st_we    = wr_en && wr_map.valid;
  assign st_wdata = field_merge(words_rd[WSLOT], wr_map, wr_data);

  pnrf_storage #(.NUM_PHYS(NUM_PHYS), .NUM_RD(NLOOK)) u_store (
    .clk, .rst_n, .we(st_we), .waddr(look_phys[WSLOT]), .wdata(st_wdata),
    .raddr(look_phys), .rdata(words_rd)
  );

  for (genvar g = 0; g < NUM_RP; g++) begin : g_rp
    pnrf_extract u_ext (.word(words_rd[g]), .m(look_map[g]), .value(rd_val[g]));
  end

  assign rd_data0 = rd_val[0];
  assign rd_data1 = rd_val[1];
endmodule

// File: rtl/pnrf_checker.sv
module pnrf_checker
  import pnrf_pkg::*;
#(
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [OFF_W-1:0]  cfg_off,
  input logic [WID_W-1:0]  cfg_width,
  input logic              cfg_err,
  input logic [AW-1:0]     rd_addr0,
  input logic [WORD_W-1:0] rd_data0,
  input map_t              rd0_map,
  input logic              st_we
);
  logic [WID_W:0] cfg_top;
  logic           bad_cfg;
  assign cfg_top = {1'b0, cfg_width} + (WID_W+1)'(cfg_off);
  assign bad_cfg = (cfg_width == '0) || (cfg_top > (WID_W+1)'(WORD_W));

  a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && bad_cfg |=> cfg_err);

  a_r2_accept_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && bad_cfg) |=> !cfg_err);

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0_map.valid |-> rd_data0 == '0);

  a_r4_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_map.valid && !rd0_map.sgn && rd0_map.width < WID_W'(WORD_W)
      |-> (rd_data0 >> rd0_map.width) == '0);

  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_map.valid && rd0_map.sgn && rd0_map.width != '0 && rd0_map.width < WID_W'(WORD_W)
      |-> (($signed(rd_data0) >>> (rd0_map.width - WID_W'(1))) == '0) ||
          (($signed(rd_data0) >>> (rd0_map.width - WID_W'(1))) == '1));

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr0) && !$past(st_we) && !$past(cfg_we) |-> $stable(rd_data0));
endmodule

bind pnrf_top pnrf_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_width(cfg_width),
  .cfg_err(cfg_err), .rd_addr0(rd_addr0), .rd_data0(rd_data0), .rd0_map(rd0_map),
  .st_we(st_we)
);

// File: tb/pnrf_top_bench.sv
module pnrf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_reg = '0;
  logic [2:0]  cfg_phys = '0;
  logic [4:0]  cfg_off = '0;
  logic [5:0]  cfg_width = '0;
  logic        cfg_signed = 1'b0;
  logic        cfg_err;
  logic [3:0]  rd_addr0 = '0;
  logic [31:0] rd_data0;
  logic [3:0]  rd_addr1 = '0;
  logic [31:0] rd_data1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pnrf_top u_pnrf_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd0(input logic [3:0] a, input string req, input logic [31:0] exp);
    rd_addr0 = a;
    #1;
    check(req, rd_data0, exp);
  endtask

  task automatic do_cfg(input logic [3:0] r, input logic [2:0] p, input logic [4:0] o,
                        input logic [5:0] w, input logic s, input logic exp_err);
    @(negedge clk);
    cfg_we = 1; cfg_reg = r; cfg_phys = p; cfg_off = o; cfg_width = w; cfg_signed = s;
    @(negedge clk);
    cfg_we = 0;
    check(exp_err ? "R3 err flag" : "R2 no err", {31'b0, cfg_err}, {31'b0, exp_err});
    @(negedge clk);
    check("R3 err one cycle", {31'b0, cfg_err}, 32'h0);
  endtask

  task automatic do_wr(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 cfg_err reset", {31'b0, cfg_err}, 32'h0);
    rd0(4'd1, "R1 unmapped read", 32'h0);
    rd_addr1 = 4'd6; #1;
    check("R1 unmapped read port1", rd_data1, 32'h0);
  endtask

  task automatic t_config;
    do_cfg(4'd1, 3'd0, 5'd0,  6'd8,  1'b0, 1'b0);
    do_cfg(4'd2, 3'd0, 5'd8,  6'd24, 1'b1, 1'b0);
    do_cfg(4'd3, 3'd1, 5'd0,  6'd6,  1'b0, 1'b0);
    do_cfg(4'd4, 3'd1, 5'd6,  6'd6,  1'b1, 1'b0);
    do_cfg(4'd6, 3'd2, 5'd0,  6'd32, 1'b0, 1'b0);
  endtask

  task automatic t_rejects;
    do_cfg(4'd7, 3'd3, 5'd28, 6'd8,  1'b0, 1'b1);
    do_cfg(4'd8, 3'd3, 5'd0,  6'd0,  1'b0, 1'b1);
    do_cfg(4'd1, 3'd4, 5'd1,  6'd33, 1'b1, 1'b1);
    do_wr(4'd7, 32'hFFFF_FFFF);
    rd0(4'd7, "R3 refused reg stays unmapped", 32'h0);
  endtask

  task automatic t_packing;
    do_wr(4'd1, 32'h0000_01AB);
    rd0(4'd1, "R7 high bits dropped", 32'h0000_00AB);
    do_wr(4'd2, 32'h0080_0001);
    rd0(4'd2, "R5 sign extend", 32'hFF80_0001);
    rd0(4'd1, "R6 neighbour kept", 32'h0000_00AB);
    do_wr(4'd1, 32'h0000_0055);
    rd0(4'd2, "R6 neighbour kept after rewrite", 32'hFF80_0001);
    rd0(4'd1, "R3 refused remap kept old map", 32'h0000_0055);
    do_wr(4'd3, 32'd50);
    do_wr(4'd4, 32'hFFFF_FFFB);
    rd0(4'd4, "R5 sign negative 6-bit", 32'hFFFF_FFFB);
    rd0(4'd3, "R4 unsigned 6-bit", 32'd50);
    do_wr(4'd4, 32'd31);
    rd0(4'd4, "R5 positive signed", 32'd31);
    do_wr(4'd6, 32'hDEAD_BEEF);
    rd0(4'd6, "R11 full word", 32'hDEAD_BEEF);
  endtask

  task automatic t_two_ports;
    @(negedge clk);
    rd_addr0 = 4'd3; rd_addr1 = 4'd2; #1;
    check("R8 port0", rd_data0, 32'd50);
    check("R8 port1", rd_data1, 32'hFF80_0001);
  endtask

  task automatic t_collision;
    @(negedge clk);
    wr_en = 1; wr_reg = 4'd3; wr_data = 32'd7;
    rd0(4'd3, "R9 old value same cycle", 32'd50);
    @(negedge clk);
    wr_en = 0;
    rd0(4'd3, "R9 new value next cycle", 32'd7);
  endtask

  task automatic t_unmapped_write;
    do_wr(4'd9, 32'hFFFF_FFFF);
    rd0(4'd1, "R10 word0 low untouched", 32'h0000_0055);
    rd0(4'd2, "R10 word0 high untouched", 32'hFF80_0001);
    rd0(4'd9, "R10 unmapped reads zero", 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_config();
    t_rejects();
    t_packing();
    t_two_ports();
    t_collision();
    t_unmapped_write();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule